// File: doc/BRIEF.md
# Programmable Clocked One-Shot Pulse Generator

This block produces a single output pulse of programmable length each time a rising edge appears on its trigger input. The length, counted in clock cycles, is a fixed inherent width plus an address word multiplied by a unit increment. Address zero therefore gives the shortest pulse. The address word is 8 or 12 bits wide, chosen by a parameter. A true output and its inverse are both driven.

While a pulse runs, further trigger edges are ignored. After the pulse ends, a recovery interval must pass before a new edge is accepted. A halt input cuts a running pulse short. Triggers are also refused while halt is held and for a recovery interval after it is released.

The address path has two modes, selected by an enable pin. With the enable high, the address inputs are used as they are. With the enable low, the block uses the value captured at the last clock edge where the enable was high. In both modes the address is sampled once, at the clock edge that accepts the trigger. Timing comes from a down-counter of clock ticks.

Top module: `pg_oneshot`

## Requirements
- R1: A pulse starts only on a trigger edge: a clock edge that samples `trig_in` high, where the previous edge sampled it low. A level held high never starts a second pulse. `pulse_o` goes high in the cycle after the accepting edge.
- R2: The pulse stays high for exactly `INH_CYC + addr * INC_CYC` clock cycles. Here `addr` is the unsigned value of the selected address at the accepting edge.
- R3: The address is `ADDR_W` bits wide (8 or 12), and every value from 0 to 2^ADDR_W-1 is usable. Address 0 gives `INH_CYC` cycles, and the all-ones address gives `INH_CYC + (2^ADDR_W-1)*INC_CYC` cycles.
- R4: Trigger edges that arrive while `pulse_o` is high are ignored, and the running pulse keeps its width.
- R5: After a pulse ends on its own, `pulse_o` stays low for at least `RECOV_CYC` cycles. A trigger edge sampled fewer than `RECOV_CYC` edges after the last high cycle is ignored. An edge sampled exactly `RECOV_CYC` edges later is accepted.
- R6: When a clock edge samples `halt_in` high, `pulse_o` is low from the next cycle on. Trigger edges are ignored while halt is high and at the first `RECOV_CYC` edges that sample halt low. A trigger edge at the edge after those is accepted.
- R7: With `addr_en` = 1, the pulse uses `addr_in` as sampled at the accepting edge. With `addr_en` = 0, it uses the `addr_in` value from the last clock edge that sampled `addr_en` high. Changes on `addr_in` while `addr_en` is low have no effect.
- R8: Changing `addr_in` or the held address while a pulse runs does not change that pulse's width. The next pulse uses the new address.
- R9: `pulse_n_o` is always the inverse of `pulse_o`.
- R10: Synchronous active-high `rst` drives `pulse_o` low and `pulse_n_o` high, clears the counters and the recovery state, and sets the held address to 0. A trigger that is already high when reset ends does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| trig_in | input | 1 | Trigger; its rising edge starts a pulse |
| halt_in | input | 1 | Ends a running pulse and blocks triggers |
| addr_en | input | 1 | 1 = transparent address, 0 = use the held address |
| addr_in | input | ADDR_W | Pulse width address word |
| pulse_o | output | 1 | True pulse output |
| pulse_n_o | output | 1 | Inverse pulse output |

## Verification
The bench checks the recovery boundary from both sides, after a pulse that ends on its own and after halt is released. A design with an off-by-one recovery counter would either accept the early edge or drop the on-time edge. Triggers held high through reset and through a whole pulse catch a level-sensitive start, which would fire twice. Address changes made during a pulse, in both modes, catch a design that keeps reading the live address instead of the value sampled at the trigger. Addresses 0 and 255 catch a wrong inherent offset or an overflow in the width product.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        PG_IDLE    = 2'd0,
        PG_ACTIVE  = 2'd1,
        PG_RECOVER = 2'd2
    } pg_state_e;

    typedef struct packed {
        logic fire;
        logic halt;
    } pg_ctrl_t;

    function automatic int unsigned pg_max_width(int unsigned aw, int unsigned inh,
                                                 int unsigned inc);
        return inh + ((32'd1 << aw) - 32'd1) * inc;
    endfunction

    function automatic bit pg_is_pow2(int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int unsigned pg_log2(int unsigned v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v > (32'd1 << i)) r = i + 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pg_trig_edge.sv
module pg_trig_edge
    import pg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     trig_in,
    input  logic     halt_in,
    output pg_ctrl_t ctrl
);
    logic trig_q;

    // During reset the stored level tracks the input, so a trigger already
    // high when reset ends is not taken as an edge.
    always_ff @(posedge clk) begin
        trig_q <= trig_in;
    end

    always_comb begin
        ctrl.halt = halt_in;
        ctrl.fire = trig_in & ~trig_q & ~halt_in & ~rst;
    end
endmodule

// File: rtl/pg_addr_path.sv
module pg_addr_path #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_sel
);
    logic [ADDR_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (addr_en) begin
            held_q <= addr_in;
        end
    end

    assign addr_sel = addr_en ? addr_in : held_q;
endmodule

// File: rtl/pg_width_calc.sv
module pg_width_calc
    import pg_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INH_CYC = 3,
    parameter int INC_CYC = 2,
    parameter int CNT_W   = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  width
);
    localparam bit INC_IS_P2 = pg_is_pow2(INC_CYC);
    localparam int INC_SH    = pg_log2(INC_CYC);

    logic [CNT_W-1:0] prod;

    generate
        if (INC_IS_P2) begin : g_shift
            assign prod = CNT_W'(addr) << INC_SH;
        end else begin : g_mult
            assign prod = CNT_W'(addr) * CNT_W'(INC_CYC);
        end
    endgenerate

    assign width = prod + CNT_W'(INH_CYC);
endmodule

// File: rtl/pg_timer.sv
module pg_timer
    import pg_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int RECOV_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  pg_ctrl_t         ctrl,
    input  logic [CNT_W-1:0] width,
    output logic             pulse
);
    localparam int RC_W = $clog2(RECOV_CYC + 1);
    localparam logic [RC_W-1:0] RC_FULL = RC_W'(RECOV_CYC);
    localparam logic [RC_W-1:0] RC_END  = RC_W'(RECOV_CYC - 1);

    pg_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [RC_W-1:0]  rc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PG_IDLE;
            cnt_q <= '0;
            rc_q  <= '0;
        end else if (ctrl.halt) begin
            st_q  <= PG_RECOVER;
            cnt_q <= '0;
            rc_q  <= RC_FULL;
        end else begin
            case (st_q)
                PG_IDLE: begin
                    if (ctrl.fire) begin
                        st_q  <= PG_ACTIVE;
                        cnt_q <= width - CNT_W'(1);
                    end
                end
                PG_ACTIVE: begin
                    if (cnt_q == '0) begin
                        st_q <= PG_RECOVER;
                        rc_q <= RC_END;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PG_RECOVER: begin
                    if (rc_q == '0) begin
                        if (ctrl.fire) begin
                            st_q  <= PG_ACTIVE;
                            cnt_q <= width - CNT_W'(1);
                        end else begin
                            st_q <= PG_IDLE;
                        end
                    end else begin
                        rc_q <= rc_q - RC_W'(1);
                    end
                end
                default: st_q <= PG_IDLE;
            endcase
        end
    end

    assign pulse = (st_q == PG_ACTIVE);
endmodule

// File: rtl/pg_oneshot.sv
module pg_oneshot
    import pg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int INH_CYC   = 3,
    parameter int INC_CYC   = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    input  logic              halt_in,
    input  logic              addr_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              pulse_o,
    output logic              pulse_n_o
);
    localparam int CNT_W = $clog2(pg_max_width(ADDR_W, INH_CYC, INC_CYC) + 1);

    pg_ctrl_t          ctrl;
    logic [ADDR_W-1:0] addr_sel;
    logic [CNT_W-1:0]  width;
    logic              pulse;

    pg_trig_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .halt_in (halt_in),
        .ctrl    (ctrl)
    );

    pg_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .addr_en  (addr_en),
        .addr_in  (addr_in),
        .addr_sel (addr_sel)
    );

    pg_width_calc #(
        .ADDR_W  (ADDR_W),
        .INH_CYC (INH_CYC),
        .INC_CYC (INC_CYC),
        .CNT_W   (CNT_W)
    ) u_width (
        .addr  (addr_sel),
        .width (width)
    );

    pg_timer #(.CNT_W(CNT_W), .RECOV_CYC(RECOV_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .width (width),
        .pulse (pulse)
    );

    assign pulse_o   = pulse;
    assign pulse_n_o = ~pulse;
endmodule

// File: rtl/pg_oneshot_chk.sv
module pg_oneshot_chk #(
    parameter int ADDR_W    = 8,
    parameter int INH_CYC   = 3,
    parameter int INC_CYC   = 2,
    parameter int RECOV_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_in,
    input logic              halt_in,
    input logic              addr_en,
    input logic [ADDR_W-1:0] addr_sel,
    input logic              pulse_o
);
    logic              prev_pulse;
    logic [ADDR_W-1:0] prev_addr;
    logic [31:0]       run_len;
    logic [31:0]       exp_w;
    logic              halted;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pulse <= 1'b0;
            prev_addr  <= '0;
            run_len    <= '0;
            exp_w      <= '0;
            halted     <= 1'b0;
        end else begin
            prev_pulse <= pulse_o;
            prev_addr  <= addr_sel;
            if (pulse_o && !prev_pulse) begin
                run_len <= 32'd1;
                exp_w   <= 32'(INH_CYC) + 32'(prev_addr) * 32'(INC_CYC);
                halted  <= halt_in;
            end else begin
                if (pulse_o) run_len <= run_len + 32'd1;
                halted <= halted | halt_in;
            end
        end
    end

    // R1: a pulse begins only after a sampled low-to-high trigger step
    p_edge_only_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> ($past(trig_in) && !$past(trig_in, 2)));

    // R2: an unhalted pulse lasts the programmed number of cycles
    p_width_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_pulse && !pulse_o && !halted) |-> (run_len == exp_w));

    // R6: halt ends the pulse in the next cycle
    p_halt_ends_r6: assert property (@(posedge clk) disable iff (rst)
        halt_in |=> !pulse_o);

    // R7: with the enable low the selected address holds still
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!addr_en && $past(!addr_en)) |-> $stable(addr_sel));

    generate
        if (RECOV_CYC >= 2) begin : g_gap
            // R5: at least one quiet cycle follows the end of a pulse
            p_gap_r5: assert property (@(posedge clk) disable iff (rst)
                $fell(pulse_o) |=> !pulse_o);
        end
    endgenerate
endmodule

bind pg_oneshot pg_oneshot_chk #(
    .ADDR_W    (ADDR_W),
    .INH_CYC   (INH_CYC),
    .INC_CYC   (INC_CYC),
    .RECOV_CYC (RECOV_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig_in  (trig_in),
    .halt_in  (halt_in),
    .addr_en  (addr_en),
    .addr_sel (addr_sel),
    .pulse_o  (pulse_o)
);

// File: tb/pg_oneshot_tb_top.sv
`timescale 1ns/1ps
module pg_oneshot_tb_top;
    localparam int AW    = 8;
    localparam int INH   = 3;
    localparam int INC   = 2;
    localparam int RECOV = 2;
    localparam int NV    = 8;
    localparam int V_ADDR [NV] = '{0, 1, 2, 17, 100, 255, 64, 9};
    localparam bit V_LAT  [NV] = '{0, 0, 1, 0, 1, 0, 1, 1};

    logic          clk = 1'b0;
    logic          rst;
    logic          trig_in;
    logic          halt_in;
    logic          addr_en;
    logic [AW-1:0] addr_in;
    logic          pulse_o;
    logic          pulse_n_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pg_oneshot #(.ADDR_W(AW), .INH_CYC(INH), .INC_CYC(INC), .RECOV_CYC(RECOV)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (trig_in),
        .halt_in   (halt_in),
        .addr_en   (addr_en),
        .addr_in   (addr_in),
        .pulse_o   (pulse_o),
        .pulse_n_o (pulse_n_o)
    );

    function automatic int exp_width(int a);
        return INH + a * INC;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_high(output int w);
        w = 0;
        while (pulse_o && w < 5000) begin
            w++;
            chk(pulse_n_o == ~pulse_o, "R9 inverse output", int'(pulse_n_o), int'(~pulse_o));
            @(negedge clk);
        end
    endtask

    task automatic fire_measure(output int w);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        count_high(w);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic watch_low(int n, string req);
        int seen;
        seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (pulse_o) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        rst = 1'b1; trig_in = 1'b1; halt_in = 1'b0; addr_en = 1'b1; addr_in = '0;
        idle(4);
        // R10 reset state with trigger held high
        chk(pulse_o == 1'b0, "R10 reset pulse low", int'(pulse_o), 0);
        chk(pulse_n_o == 1'b1, "R10 reset inverse high", int'(pulse_n_o), 1);
        rst = 1'b0;
        watch_low(6, "R10 level high at reset end is not an edge");
        trig_in = 1'b0;
        idle(3);

        // table walk: R2 R3 R7 widths in both address modes
        for (int i = 0; i < NV; i++) begin
            addr_en = 1'b1;
            addr_in = AW'(V_ADDR[i]);
            @(negedge clk);
            if (V_LAT[i]) begin
                addr_en = 1'b0;
                addr_in = ~AW'(V_ADDR[i]);
                @(negedge clk);
            end
            fire_measure(w);
            chk(w == exp_width(V_ADDR[i]), "R2 R3 R7 table width", w, exp_width(V_ADDR[i]));
            idle(RECOV + 2);
        end

        // R1: trigger held high through and after a pulse gives one pulse only
        addr_en = 1'b1; addr_in = AW'(4);
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        count_high(w);
        chk(w == exp_width(4), "R1 held trigger width", w, exp_width(4));
        watch_low(30, "R1 held level starts no second pulse");
        trig_in = 1'b0;
        idle(3);

        // R4: edges during an active pulse are ignored
        addr_in = AW'(20);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        w = 0;
        for (int k = 0; k < 12; k++) begin
            if (pulse_o) w++;
            trig_in = k[0];
            @(negedge clk);
        end
        trig_in = 1'b0;
        begin
            int rest;
            count_high(rest);
            w += rest;
        end
        chk(w == exp_width(20), "R4 retrigger ignored width", w, exp_width(20));

        // R5: edge one cycle early after natural end is ignored
        trig_in = 1'b0;
        addr_in = AW'(1);
        idle(4);
        fire_measure(w);
        repeat (RECOV - 2) @(negedge clk);
        trig_in = 1'b1;
        watch_low(10, "R5 early edge in recovery ignored");
        trig_in = 1'b0;
        idle(4);
        // R5: edge exactly at the end of recovery is accepted
        fire_measure(w);
        repeat (RECOV - 1) @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk(pulse_o == 1'b1, "R5 on-time edge accepted", int'(pulse_o), 1);
        count_high(w);
        chk(w == exp_width(1), "R5 on-time pulse width", w, exp_width(1));
        idle(4);

        // R6: halt ends a long pulse early
        addr_in = AW'(50);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        idle(5);
        chk(pulse_o == 1'b1, "R6 pulse running before halt", int'(pulse_o), 1);
        halt_in = 1'b1;
        @(negedge clk);
        chk(pulse_o == 1'b0, "R6 halt ends pulse", int'(pulse_o), 0);
        trig_in = 1'b1;
        watch_low(3, "R6 edge during halt ignored");
        trig_in = 1'b0;
        @(negedge clk);
        halt_in = 1'b0;
        repeat (RECOV - 1) @(negedge clk);
        trig_in = 1'b1;
        watch_low(10, "R6 early edge after halt release ignored");
        trig_in = 1'b0;
        halt_in = 1'b1;
        @(negedge clk);
        halt_in = 1'b0;
        repeat (RECOV) @(negedge clk);
        addr_in = AW'(2);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        chk(pulse_o == 1'b1, "R6 edge after halt recovery accepted", int'(pulse_o), 1);
        count_high(w);
        chk(w == exp_width(2), "R6 pulse after halt width", w, exp_width(2));
        idle(4);

        // R7 R8: latched address reloaded during a pulse affects only the next one
        addr_en = 1'b1; addr_in = AW'(10);
        @(negedge clk);
        addr_en = 1'b0; addr_in = AW'(99);
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        w = 0;
        for (int k = 0; k < 3; k++) begin
            if (pulse_o) w++;
            addr_en = (k == 1);
            addr_in = AW'(30);
            @(negedge clk);
        end
        addr_in = AW'(77);
        begin
            int rest;
            count_high(rest);
            w += rest;
        end
        chk(w == exp_width(10), "R8 latched change mid-pulse", w, exp_width(10));
        idle(4);
        fire_measure(w);
        chk(w == exp_width(30), "R7 R8 next pulse uses new held address", w, exp_width(30));
        idle(4);

        // R8: transparent address change mid-pulse
        addr_en = 1'b1; addr_in = AW'(12);
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        addr_in = '0;
        count_high(w);
        chk(w == exp_width(12), "R8 transparent change mid-pulse", w, exp_width(12));
        idle(4);

        // R10: reset in the middle of a pulse
        addr_in = AW'(40);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        idle(3);
        rst = 1'b1;
        @(negedge clk);
        chk(pulse_o == 1'b0, "R10 reset clears running pulse", int'(pulse_o), 0);
        rst = 1'b0;
        addr_en = 1'b0;
        idle(1);
        fire_measure(w);
        chk(w == exp_width(0), "R10 held address cleared by reset", w, exp_width(0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule